// File: doc/BRIEF.md
# Run-of-Threes Reference Pattern Source and Density Meter

This test block drives a slope-delta decoder under test with one of four fixed, repeating reference bit sequences. Two selects choose the sequence. The rate select picks a 20-bit sequence for the slow rate or a 40-bit sequence for the fast rate. The density select picks a sparse sequence, which never holds a run of three equal bits, or a dense sequence, in which three in ten bit periods follow such a run. One bit leaves the block on each cycle that carries the bit-clock enable. The bit is sent from the most significant end of the sequence, and the sequence wraps to its start when it runs out.

A second path measures density. On each bit enable it takes one bit, either the generator's own bit or an external stream. It keeps a short history of the bits it has taken and raises a flag for the bit period after any three equal bits in a row. It counts those flagged periods over a fixed window of bit periods. When the window closes, it gives a one-cycle strobe with both counts and starts the next window at once. A change of either select restarts the sequence at its first bit, empties the history and restarts the window.

Top module: `rpg_top`

## Requirements
- R1: `pat_bit` changes only at a rising clock edge where `bit_en` is high. Between enables it holds its value, even when the selects change.
- R2: With `rate_sel`=0 and `dens_sel`=0, the emitted bits repeat the 20-bit value 0xDB492, most significant bit first.
- R3: With `rate_sel`=1 and `dens_sel`=0, the emitted bits repeat the 40-bit value 0xDB54924AB6, most significant bit first.
- R4: With `rate_sel`=0 and `dens_sel`=1, the emitted bits repeat the 20-bit value 0xFB412, most significant bit first.
- R5: With `rate_sel`=1 and `dens_sel`=1, the emitted bits repeat the 40-bit value 0xFDAA10255E, most significant bit first.
- R6: At the first `bit_en` after either select differs from the last pair used, the block does three things. It emits the first bit of the new sequence. The sampled bit becomes the only bit in the history. The window count restarts at that bit.
- R7: `mon_flag` is set for the bit period that follows a `bit_en` at which the sampled bit and the two bits sampled before it (with no clear in between) are all equal. It is cleared after any other enable, and it holds between enables.
- R8: After each `WIN_BITS` sampled bits, `win_done` is high for exactly one cycle. At the same time `win_total` equals `WIN_BITS` and `win_hits` equals the number of coincidences in that window. The next window begins with the following sample.
- R9: With `mon_ext`=1 the meter samples `mon_bit`. With `mon_ext`=0 it samples the bit the generator emits at that same enable.
- R10: When the meter samples the generator and `WIN_BITS` is 200, a full window gives 0 hits for either sparse sequence and 60 hits (0.30) for either dense sequence.
- R11: After reset, `pat_bit`, `mon_flag`, `win_done`, `win_hits` and `win_total` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable, one bit per high cycle |
| rate_sel | input | 1 | 0: 20-bit sequence, 1: 40-bit sequence |
| dens_sel | input | 1 | 0: sparse sequence, 1: dense sequence |
| mon_ext | input | 1 | Meter source: 1 external bit, 0 generator bit |
| mon_bit | input | 1 | External bit stream for the meter |
| pat_bit | output | 1 | Emitted reference bit |
| mon_flag | output | 1 | Coincidence flag for the current bit period |
| win_done | output | 1 | One-cycle strobe at the end of a window |
| win_hits | output | CNT_W | Flagged periods in the last window |
| win_total | output | CNT_W | Bit periods in the last window |

## Verification
The bench runs all four sequences back to back. Each one runs long enough to wrap and to fill a full window, and the 40-bit sequences are cut off part way through. This shows that a sequence restarts at its first bit on a select change and not at its old position. The sparse and dense sequences together tell a meter that never fires apart from one that counts correctly: the sparse ones must give zero hits and the dense ones exactly 60 in 200. External streams separate the run rule from the sequence content. These are all ones (every period flagged once the history fills), a strict alternation (nothing flagged) and a pseudo-random stream. A select change made while the external stream is running shows that the history and the window are cleared.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    localparam int unsigned LEN_SLOW = 20;
    localparam int unsigned LEN_FAST = 40;
    localparam int unsigned SEQ_W    = 40;
    localparam int unsigned IDX_W    = $clog2(LEN_FAST);

    localparam logic [SEQ_W-1:0] SEQ_SLOW_SPARSE = 40'h00000DB492;
    localparam logic [SEQ_W-1:0] SEQ_FAST_SPARSE = 40'hDB54924AB6;
    localparam logic [SEQ_W-1:0] SEQ_SLOW_DENSE  = 40'h00000FB412;
    localparam logic [SEQ_W-1:0] SEQ_FAST_DENSE  = 40'hFDAA10255E;

    typedef struct packed {
        logic fast;
        logic dense;
    } seq_sel_t;

    function automatic int unsigned seq_len(input logic fast);
        return fast ? LEN_FAST : LEN_SLOW;
    endfunction

    function automatic logic seq_bit(input seq_sel_t sel, input logic [IDX_W-1:0] idx);
        logic [SEQ_W-1:0] word;
        logic [IDX_W-1:0] pos;
        case ({sel.fast, sel.dense})
            2'b00:   word = SEQ_SLOW_SPARSE;
            2'b10:   word = SEQ_FAST_SPARSE;
            2'b01:   word = SEQ_SLOW_DENSE;
            default: word = SEQ_FAST_DENSE;
        endcase
        pos = IDX_W'(seq_len(sel.fast) - 1) - idx;
        return word[pos];
    endfunction

endpackage

// File: rtl/rpg_pattern_gen.sv
module rpg_pattern_gen
    import rpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_en,
    input  seq_sel_t sel,
    output logic     cur_bit,
    output logic     restart,
    output logic     pat_bit
);

    typedef struct packed {
        seq_sel_t         sel;
        logic [IDX_W-1:0] idx;
        logic             bit_o;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic [IDX_W-1:0] idx_eff;

    always_comb begin
        st_d    = st_q;
        restart = bit_en && (sel != st_q.sel);
        idx_eff = restart ? '0 : st_q.idx;
        cur_bit = seq_bit(sel, idx_eff);
        if (bit_en) begin
            st_d.sel   = sel;
            st_d.bit_o = cur_bit;
            if (32'(idx_eff) == seq_len(sel.fast) - 1)
                st_d.idx = '0;
            else
                st_d.idx = idx_eff + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pat_bit = st_q.bit_o;

    AST_PAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(pat_bit)); // R1
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.idx) < seq_len(st_q.sel.fast)); // R2
    AST_RESTART_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> st_q.idx == IDX_W'(1)); // R6

endmodule

// File: rtl/rpg_rot_detector.sv
module rpg_rot_detector #(
    parameter int unsigned RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic clr,
    input  logic bit_in,
    output logic hit,
    output logic flag
);

    localparam int unsigned HIST_W = RUN_LEN - 1;
    localparam int unsigned FILL_W = $clog2(RUN_LEN);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [FILL_W-1:0] fill;
        logic              flag;
    } det_st_t;

    det_st_t st_d, st_q;
    logic [HIST_W-1:0] eq_vec;
    logic              all_eq;

    for (genvar g = 0; g < HIST_W; g++) begin : g_eq
        assign eq_vec[g] = (st_q.hist[g] == bit_in);
    end

    assign all_eq = &eq_vec;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (smp_en) begin
            if (clr) begin
                st_d.hist    = '0;
                st_d.hist[0] = bit_in;
                st_d.fill    = FILL_W'(1);
            end else begin
                hit       = (32'(st_q.fill) == HIST_W) && all_eq;
                st_d.hist = {st_q.hist[HIST_W-2:0], bit_in};
                if (32'(st_q.fill) < HIST_W)
                    st_d.fill = st_q.fill + 1'b1;
            end
            st_d.flag = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_en |=> $stable(flag)); // R7
    AST_CLEAR_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && clr) |=> !flag); // R6
    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.fill) <= HIST_W); // R7

endmodule

// File: rtl/rpg_density_window.sv
module rpg_density_window #(
    parameter int unsigned WIN_BITS = 200,
    parameter int unsigned CNT_W    = $clog2(WIN_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_en,
    input  logic             clr,
    input  logic             hit,
    output logic             done,
    output logic [CNT_W-1:0] hits,
    output logic [CNT_W-1:0] total
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] acc;
        logic             done;
        logic [CNT_W-1:0] out_hits;
        logic [CNT_W-1:0] out_total;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [CNT_W-1:0] cnt_nx, acc_nx;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        cnt_nx    = (clr ? '0 : st_q.cnt) + 1'b1;
        acc_nx    = (clr ? '0 : st_q.acc) + CNT_W'(hit);
        if (smp_en) begin
            if (32'(cnt_nx) == WIN_BITS) begin
                st_d.done      = 1'b1;
                st_d.out_hits  = acc_nx;
                st_d.out_total = cnt_nx;
                st_d.cnt       = '0;
                st_d.acc       = '0;
            end else begin
                st_d.cnt = cnt_nx;
                st_d.acc = acc_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done  = st_q.done;
    assign hits  = st_q.out_hits;
    assign total = st_q.out_total;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_HITS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hits <= total); // R8
    AST_CNT_BELOW_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.cnt) < WIN_BITS); // R8
    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc <= st_q.cnt); // R8

endmodule

// File: rtl/rpg_top.sv
module rpg_top
    import rpg_pkg::*;
#(
    parameter int unsigned WIN_BITS = 200,
    parameter int unsigned RUN_LEN  = 3,
    localparam int unsigned CNT_W   = $clog2(WIN_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rate_sel,
    input  logic             dens_sel,
    input  logic             mon_ext,
    input  logic             mon_bit,
    output logic             pat_bit,
    output logic             mon_flag,
    output logic             win_done,
    output logic [CNT_W-1:0] win_hits,
    output logic [CNT_W-1:0] win_total
);

    seq_sel_t sel;
    logic     gen_bit, restart, smp_bit, hit;

    assign sel.fast  = rate_sel;
    assign sel.dense = dens_sel;

    rpg_pattern_gen u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .sel     (sel),
        .cur_bit (gen_bit),
        .restart (restart),
        .pat_bit (pat_bit)
    );

    assign smp_bit = mon_ext ? mon_bit : gen_bit;

    rpg_rot_detector #(.RUN_LEN(RUN_LEN)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (bit_en),
        .clr    (restart),
        .bit_in (smp_bit),
        .hit    (hit),
        .flag   (mon_flag)
    );

    rpg_density_window #(.WIN_BITS(WIN_BITS), .CNT_W(CNT_W)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (bit_en),
        .clr    (restart),
        .hit    (hit),
        .done   (win_done),
        .hits   (win_hits),
        .total  (win_total)
    );

    AST_INT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !mon_ext) |=> pat_bit == $past(smp_bit)); // R9
    AST_DONE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> 32'(win_total) == WIN_BITS); // R8

endmodule

// File: tb/rpg_top_test.sv
module rpg_top_test;

    localparam int unsigned WIN = 200;
    localparam int unsigned CW  = $clog2(WIN + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, rate_sel = 1'b0, dens_sel = 1'b0, mon_ext = 1'b0, mon_bit = 1'b0;
    logic pat_bit, mon_flag, win_done;
    logic [CW-1:0] win_hits, win_total;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rpg_top #(.WIN_BITS(WIN), .RUN_LEN(3)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rate_sel(rate_sel),
        .dens_sel(dens_sel), .mon_ext(mon_ext), .mon_bit(mon_bit),
        .pat_bit(pat_bit), .mon_flag(mon_flag), .win_done(win_done),
        .win_hits(win_hits), .win_total(win_total)
    );

    // bench model state
    logic m_rate = 1'b0, m_dens = 1'b0;
    int   m_idx = 0, m_fill = 0, m_cnt = 0, m_hits = 0;
    logic m_h0 = 1'b0, m_h1 = 1'b0;
    int   last_win_hits = -1;

    function automatic logic ref_bit(logic r, logic d, int i);
        logic [39:0] w;
        int len;
        len = r ? 40 : 20;
        if (!r && !d)     w = 40'h00000DB492;
        else if (r && !d) w = 40'hDB54924AB6;
        else if (!r)      w = 40'h00000FB412;
        else              w = 40'hFDAA10255E;
        return w[len - 1 - i];
    endfunction

    function automatic string seq_req(logic r, logic d);
        if (!r && !d) return "R2";
        if (r && !d)  return "R3";
        if (!r)       return "R4";
        return "R5";
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one bit period: enable for one cycle, sample at the following negedge
    task automatic step(input logic ext_bit);
        logic rs, gb, sb, ht, dn;
        int len, dh;
        rs = (rate_sel != m_rate) || (dens_sel != m_dens);
        if (rs) begin m_rate = rate_sel; m_dens = dens_sel; m_idx = 0; end
        len = m_rate ? 40 : 20;
        gb = ref_bit(m_rate, m_dens, m_idx);
        m_idx = (m_idx + 1) % len;
        sb = mon_ext ? ext_bit : gb;
        if (rs) begin
            m_fill = 1; m_h0 = sb; m_h1 = 1'b0; ht = 1'b0; m_cnt = 0; m_hits = 0;
        end else begin
            ht = (m_fill == 2) && (sb == m_h0) && (sb == m_h1);
            m_h1 = m_h0; m_h0 = sb;
            if (m_fill < 2) m_fill++;
        end
        m_cnt++;
        m_hits += int'(ht);
        dn = (m_cnt == int'(WIN));
        dh = m_hits;
        if (dn) begin m_cnt = 0; m_hits = 0; end

        mon_bit = ext_bit;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        if (!mon_ext) check(seq_req(m_rate, m_dens), int'(pat_bit), int'(gb), "pat_bit");
        else          check("R9", int'(pat_bit), int'(gb), "pat_bit in external mode");
        check(mon_ext ? "R9" : "R7", int'(mon_flag), int'(ht), "mon_flag");
        check("R8", int'(win_done), int'(dn), "win_done");
        if (dn) begin
            check("R8", int'(win_hits), dh, "win_hits");
            check("R8", int'(win_total), int'(WIN), "win_total");
            last_win_hits = int'(win_hits);
        end
        @(negedge clk);
        check("R8", int'(win_done), 0, "win_done pulse width");
        check("R7", int'(mon_flag), int'(ht), "mon_flag hold");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] lfsr;
        logic held;
        repeat (4) @(negedge clk);
        // R11: reset state
        check("R11", int'(pat_bit), 0, "pat_bit at reset");
        check("R11", int'(mon_flag), 0, "mon_flag at reset");
        check("R11", int'(win_done), 0, "win_done at reset");
        check("R11", int'(win_hits), 0, "win_hits at reset");
        check("R11", int'(win_total), 0, "win_total at reset");
        rst_n = 1'b1;
        @(negedge clk);

        // all four sequences from the generator, each cut at 210 bits (R2..R6, R10)
        for (int s = 0; s < 4; s++) begin
            rate_sel = s[0];
            dens_sel = s[1];
            last_win_hits = -1;
            for (int k = 0; k < 210; k++) step(1'b0);
            check("R10", last_win_hits, s[1] ? 60 : 0, "hits in 200-bit window");
        end

        // R1 / R6: select change without an enable leaves pat_bit alone,
        // and the next enable starts the new sequence at bit 0
        held = pat_bit;
        rate_sel = 1'b0;
        dens_sel = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", int'(pat_bit), int'(held), "pat_bit held across select change");
        step(1'b0);
        check("R6", int'(pat_bit), 1, "first bit after restart");
        for (int k = 0; k < 5; k++) step(1'b0);

        // external streams (R7, R8, R9)
        mon_ext = 1'b1;
        for (int k = 0; k < 250; k++) step(1'b1);
        for (int k = 0; k < 210; k++) step(k[0]);
        lfsr = 8'hA5;
        for (int k = 0; k < 420; k++) begin
            step(lfsr[0]);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        // R6: select change while metering an external stream clears history
        for (int k = 0; k < 4; k++) step(1'b0);
        rate_sel = 1'b1;
        step(1'b0);
        step(1'b0);
        check("R6", int'(mon_flag), 0, "no flag two bits after clear");
        for (int k = 0; k < 205; k++) step(1'b0);

        finish_run();
    end

endmodule